// File: doc/BRIEF.md
# PCI interrupt status and mask aggregator

This block collects every interrupt source of a PCI host bridge into one 32-bit register and drives a single combined request to the system interrupt controller. The four shared PCI interrupt pins are active low. Each pin passes through a synchroniser and appears as a level-following pending bit. Six classes of PCI error event arrive as single-cycle strobes and set sticky pending bits. Software clears a sticky bit by writing 1 to its position. Each pending bit at position n has an enable bit at position n+16 in the same word. A source raises the output only when both its pending bit and its enable bit are 1.

The block also contains a small combinational router. For a device on the bus, it turns the device's interrupt pin number (1 to 4) and its slot number into the index of the host interrupt line that the pin is wired to. Driver software uses the router when it sets up interrupt routing.

The enables come out of reset with the abort-class errors enabled. The parity-class and system-error sources join the reset enable set only when the parameter `ALL_ERR` is set.

Top module: `pci_irq_agg`

## Requirements
- R1: Bits 0 to 3 of `reg_rdata` are pending bits for the INTA, INTB, INTC and INTD pins, in that order. Each bit is 1 while its `intx_n` pin is low. A change on a pin shows in `reg_rdata` after exactly two rising clock edges, and is not yet visible after one. A register write does not clear these bits.
- R2: Bits 4 to 9 are sticky error pending bits for error strobes `err_evt[0]` to `err_evt[5]`. In order, these are: data parity error detected, signalled target abort, received target abort, received master abort, signalled system error and detected parity error. A strobe sets its bit, and the bit shows in `reg_rdata` after the next rising edge.
- R3: A write with bit 4+i set clears error pending bit 4+i, and a write with that bit at 0 leaves it unchanged. When a strobe and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: Every write loads `reg_wdata[25:16]` into the enable bits `reg_rdata[25:16]`. The enable for pending bit n sits at bit n+16.
- R5: `irq` is a register. After each rising edge, it equals the OR over n = 0 to 9 of (bit n AND bit n+16) of `reg_rdata` as it stood before that edge. The output therefore lags a pending or enable change by one clock.
- R6: A write of the all-zero word clears all enables and all error pending bits. The INTx bits keep following their pins.
- R7: After reset, all pending bits are 0 and `irq` is 0. With `ALL_ERR`=0 the enables are bits 21, 22 and 23, which gives `reg_rdata`=0x00E00000. With `ALL_ERR`=1, bits 20 to 25 are also set.
- R8: Bits 10 to 15 and 26 to 31 of `reg_rdata` always read 0, including after a write of all ones.
- R9: `host_intx` equals ((`dev_pin` - 1) + (`slot` mod 4)) mod 4, where `dev_pin` 1 to 4 means INTA to INTD and `host_intx` 0 to 3 means host INTA to INTD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| intx_n | input | 4 | PCI INTA..INTD pins, active low, asynchronous |
| err_evt | input | 6 | Single-cycle error event strobes, one per error class |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read value: pending bits, enable bits and zeros |
| irq | output | 1 | Combined interrupt request, registered |
| slot | input | SLOT_W | Device slot number for the pin router |
| dev_pin | input | 3 | Device interrupt pin, 1 to 4 |
| host_intx | output | 2 | Host interrupt line index chosen by the router |

## Verification
The assertions take `err_evt` to be a strobe with no useful width beyond one cycle. A strobe that stays high simply re-sets its bit on every cycle. They make no assumption about how `intx_n` changes, since the synchroniser isolates it and no property ties the pins to the register. The stimulus changes every input one time unit after a rising edge. It holds each pin pattern for at least three clocks, so every synchronised level is observed both before and after it settles. The bench sweeps all 16 pin patterns, every error class alone, and every slot and pin combination of the router.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int NUM_INTX = 4;
    localparam int NUM_ERR  = 6;
    localparam int NUM_SRC  = NUM_INTX + NUM_ERR;
    localparam int EN_OFS   = 16;
    localparam int REG_W    = 32;
    localparam int GAP_LO   = EN_OFS - NUM_SRC;
    localparam int GAP_HI   = REG_W - EN_OFS - NUM_SRC;

    // Bit positions of the sources inside the pending half of the register
    localparam int SRC_INTA = 0;
    localparam int SRC_INTB = 1;
    localparam int SRC_INTC = 2;
    localparam int SRC_INTD = 3;
    localparam int SRC_DPED = 4;   // data parity error detected
    localparam int SRC_STA  = 5;   // signalled target abort
    localparam int SRC_RTA  = 6;   // received target abort
    localparam int SRC_RMA  = 7;   // received master abort
    localparam int SRC_SSE  = 8;   // signalled system error
    localparam int SRC_DPE  = 9;   // detected parity error

    typedef struct packed {
        logic [NUM_ERR-1:0]  err;
        logic [NUM_INTX-1:0] intx;
    } pend_t;

    function automatic logic [NUM_SRC-1:0] default_en(input bit all_err);
        logic [NUM_SRC-1:0] e;
        e = '0;
        e[SRC_STA] = 1'b1;
        e[SRC_RTA] = 1'b1;
        e[SRC_RMA] = 1'b1;
        if (all_err) begin
            e[SRC_DPED] = 1'b1;
            e[SRC_SSE]  = 1'b1;
            e[SRC_DPE]  = 1'b1;
        end
        return e;
    endfunction

    function automatic logic [REG_W-1:0] pack_reg(input logic [NUM_SRC-1:0] en,
                                                  input pend_t p);
        return {{GAP_HI{1'b0}}, en, {GAP_LO{1'b0}}, p};
    endfunction

endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] in_n,
    output logic [W-1:0] level
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], ~in_n[b]};
        end
        assign level[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/pirq_errlat.sv
module pirq_errlat #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_mask,
    input  logic         clr_all,
    output logic [N-1:0] pend
);
    for (genvar i = 0; i < N; i++) begin : g_err
        always_ff @(posedge clk) begin
            if (rst)
                pend[i] <= 1'b0;
            else if (evt[i])
                pend[i] <= 1'b1;
            else if (clr_all || (clr_wr && clr_mask[i]))
                pend[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/pirq_route.sv
module pirq_route #(
    parameter int SLOT_W = 5
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic [2:0]        dev_pin,
    output logic [1:0]        host_intx
);
    // Adding 3 equals subtracting 1 modulo 4; only the low two bits matter
    assign host_intx = 2'(slot + SLOT_W'(dev_pin) + SLOT_W'(3));
endmodule

// File: rtl/pci_irq_agg.sv
module pci_irq_agg
    import pirq_pkg::*;
#(
    parameter bit ALL_ERR     = 1'b0,
    parameter int SLOT_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        intx_n,
    input  logic [5:0]        err_evt,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    input  logic [SLOT_W-1:0] slot,
    input  logic [2:0]        dev_pin,
    output logic [1:0]        host_intx
);
    pend_t              pend;
    logic [NUM_SRC-1:0] en_q;
    logic               zero_wr;

    assign zero_wr = reg_wr && (reg_wdata == '0);

    pirq_sync #(.W(NUM_INTX), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .in_n  (intx_n),
        .level (pend.intx)
    );

    pirq_errlat #(.N(NUM_ERR)) u_err (
        .clk      (clk),
        .rst      (rst),
        .evt      (err_evt),
        .clr_wr   (reg_wr),
        .clr_mask (reg_wdata[SRC_DPED +: NUM_ERR]),
        .clr_all  (zero_wr),
        .pend     (pend.err)
    );

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= default_en(ALL_ERR);
        else if (reg_wr)
            en_q <= reg_wdata[EN_OFS +: NUM_SRC];
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(en_q & pend);
    end

    assign reg_rdata = pack_reg(en_q, pend);

    pirq_route #(.SLOT_W(SLOT_W)) u_route (
        .slot      (slot),
        .dev_pin   (dev_pin),
        .host_intx (host_intx)
    );
endmodule

// File: rtl/pci_irq_agg_chk.sv
module pci_irq_agg_chk (
    input logic        clk,
    input logic        rst,
    input logic [5:0]  err_evt,
    input logic        reg_wr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        irq
);
    // R2: a strobe leaves its pending bit set after the next edge
    a_r2_evt_sets: assert property (@(posedge clk) disable iff (rst)
        (|err_evt) |=> ((reg_rdata[9:4] & $past(err_evt)) == $past(err_evt)));

    // R3: without a write, no set error bit is lost
    a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
        !reg_wr |=> ((reg_rdata[9:4] & $past(reg_rdata[9:4])) == $past(reg_rdata[9:4])));

    // R4: a write loads the enables
    a_r4_en_load: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> (reg_rdata[25:16] == $past(reg_wdata[25:16])));

    // R5: output follows the masked pending set one clock later
    a_r5_irq_lag: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == |($past(reg_rdata[25:16]) & $past(reg_rdata[9:0]))));

    // R6: a zero write with no strobe empties enables and error bits
    a_r6_zero_clear: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_wdata == 32'h0 && err_evt == 6'h0) |=> (reg_rdata[25:4] == 22'h0));

    // R8: unused positions read zero
    a_r8_gaps_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[15:10] == 6'h0) && (reg_rdata[31:26] == 6'h0));
endmodule

bind pci_irq_agg pci_irq_agg_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .err_evt   (err_evt),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq)
);

// File: tb/pci_irq_agg_test.sv
module pci_irq_agg_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  intx_n;
    logic [5:0]  err_evt;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq;
    logic [4:0]  slot;
    logic [2:0]  dev_pin;
    logic [1:0]  host_intx;

    int total = 0;
    int bad   = 0;

    logic [9:0] m_en;
    logic [5:0] m_err;
    logic [3:0] m_intx;

    always #(CLK_P/2) clk = ~clk;

    pci_irq_agg uut (
        .clk(clk), .rst(rst), .intx_n(intx_n), .err_evt(err_evt),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .slot(slot), .dev_pin(dev_pin), .host_intx(host_intx)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_reg();
        return {6'h0, m_en, 6'h0, m_err, m_intx};
    endfunction

    function automatic logic exp_irq();
        return |(m_en & {m_err, m_intx});
    endfunction

    task automatic wr(input logic [31:0] d, input logic [5:0] ev);
        reg_wr = 1'b1; reg_wdata = d; err_evt = ev;
        tick();
        reg_wr = 1'b0; reg_wdata = '0; err_evt = '0;
        m_en = d[25:16];
        if (d == 32'h0) m_err = '0;
        else            m_err = m_err & ~d[9:4];
        m_err = m_err | ev;
    endtask

    task automatic pulse(input logic [5:0] ev);
        err_evt = ev;
        tick();
        err_evt = '0;
        m_err = m_err | ev;
    endtask

    initial begin
        #(CLK_P * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; intx_n = 4'hF; err_evt = '0; reg_wr = 1'b0; reg_wdata = '0;
        slot = '0; dev_pin = 3'd1;
        m_en = 10'h0E0; m_err = '0; m_intx = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R7 reset state
        chk("R7 reset reg", reg_rdata, 32'h00E00000);
        chk("R7 reset irq", {31'h0, irq}, 32'h0);

        // R9 router sweep
        for (int s = 0; s < 32; s++) begin
            for (int p = 1; p <= 4; p++) begin
                slot = 5'(s); dev_pin = 3'(p);
                #1;
                chk("R9 route", {30'h0, host_intx}, 32'(((p - 1) + (s % 4)) % 4));
            end
        end

        // R2/R3/R5 each error class alone, default enables
        for (int i = 0; i < 6; i++) begin
            pulse(6'(1 << i));
            chk("R2 err set", reg_rdata, exp_reg());
            tick();
            chk("R5 err irq", {31'h0, irq}, {31'h0, exp_irq()});
            wr({6'h0, m_en, 16'h0} | (32'h10 << i), 6'h0);
            chk("R3 w1c", reg_rdata, exp_reg());
            tick();
            chk("R5 irq drop", {31'h0, irq}, 32'h0);
        end

        // R3 set wins over clear in the same cycle; writing 0 to a bit keeps it
        wr({6'h0, m_en, 16'h0} | 32'h40, 6'h04);
        chk("R3 set wins", reg_rdata, exp_reg());
        wr({6'h0, m_en, 16'h0}, 6'h0);
        chk("R3 zero keeps", reg_rdata, exp_reg());

        // R6 zero write
        pulse(6'h3F);
        chk("R2 all set", reg_rdata, exp_reg());
        wr(32'h0, 6'h0);
        chk("R6 zero write", reg_rdata, 32'h0);
        tick();
        chk("R6 irq off", {31'h0, irq}, 32'h0);

        // R4 enable all
        wr(32'h03FF0000, 6'h0);
        chk("R4 enable load", reg_rdata, 32'h03FF0000);

        // R1 pin sweep with timing
        for (int p = 0; p < 16; p++) begin
            logic [3:0] prev;
            prev = m_intx;
            intx_n = ~4'(p);
            tick();
            chk("R1 not yet", {28'h0, reg_rdata[3:0]}, {28'h0, prev});
            tick();
            m_intx = 4'(p);
            chk("R1 pending", reg_rdata, exp_reg());
            tick();
            chk("R5 intx irq", {31'h0, irq}, {31'h0, exp_irq()});
        end

        // R1 write cannot clear INTx
        wr(32'h03FF000F, 6'h0);
        chk("R1 no clear", reg_rdata, exp_reg());

        // R8 all-ones write
        wr(32'hFFFFFFFF, 6'h0);
        chk("R8 gaps zero", reg_rdata, 32'h03FF000F);

        // R4 selective enables: INTA and INTC only
        wr(32'h00050000, 6'h0);
        intx_n = ~4'h2;
        repeat (3) tick();
        m_intx = 4'h2;
        chk("R4 masked pin reg", reg_rdata, exp_reg());
        chk("R4 masked pin irq", {31'h0, irq}, 32'h0);
        intx_n = ~4'h4;
        repeat (3) tick();
        m_intx = 4'h4;
        chk("R4 enabled pin irq", {31'h0, irq}, 32'h1);
        intx_n = 4'hF;
        repeat (3) tick();
        m_intx = 4'h0;
        chk("R1 release", reg_rdata, exp_reg());
        chk("R5 release irq", {31'h0, irq}, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule